// File: doc/BRIEF.md
# Dual-Port Memory with Width Conversion and Byte Parity

This block is a two-port synchronous memory holding 16,384 data bits and 2,048 parity bits. Each port's width is set by its own parameter. When the two widths differ, the memory converts between them. A wide port sees several consecutive narrow words joined into one word. A narrow port sees a slice of a wide word. Every data byte owns one parity bit, and that pairing holds whichever width reads or writes it.

Each port has an enable, a write enable, an address, data and parity inputs, and data and parity outputs. Both ports share one clock and one synchronous active-low reset. The reset clears only the port output registers. Ports that are 1, 2 or 4 bits wide carry no parity. Their parity pins are one bit wide: the input is ignored and the output reads 0.

Top module: `adp_ram`

## Requirements
- R1: Each port width is one of 1, 2, 4, 9, 18 or 36 bits, and its data part is 1, 2, 4, 8, 16 or 32 bits. Its address has 14 minus log2(data bits) bits, and every address from 0 to the last one reaches a separate storage location.
- R2: A read with the enable high and the write enable low shows the stored word on the data and parity outputs after the next rising clock edge.
- R3: A write with both enables high stores the word at that edge, and the same port's outputs then show the written data and parity (write-first).
- R4: While a port's enable is low, its outputs keep their value and the memory is not written, whatever the write enable is.
- R5: A narrow word at address n fills data bits [n*D +: D] of a flat bit array, where D is that port's data width. A wide read therefore returns consecutive narrow words, with the lowest address in the least significant position.
- R6: A word written through a wide port comes back in pieces through a narrow port. Narrow address n returns wide data bits [n*D +: D] of the same flat array.
- R7: Parity bit k of any word belongs to data byte k of that word. Parity index i of the flat parity array pairs with data bits [8i +: 8], so each narrow access gets the parity of its own bytes.
- R8: On a 1, 2 or 4-bit port, the parity output is always 0. Writes through that port leave every stored parity bit unchanged.
- R9: While reset is low at a clock edge, both ports' data and parity outputs become 0 at that edge. Memory contents survive the reset.
- R10: In one cycle, the two ports may write disjoint bits of the same stored row, and both writes then take effect. Writes to overlapping bits in one cycle give an undefined result and are flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 14-log2(DA) | Port A word address |
| a_din | input | DA | Port A write data |
| a_pin | input | max(PA,1) | Port A write parity |
| a_dout | output | DA | Port A read data |
| a_pout | output | max(PA,1) | Port A read parity |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 14-log2(DB) | Port B word address |
| b_din | input | DB | Port B write data |
| b_pin | input | max(PB,1) | Port B write parity |
| b_dout | output | DB | Port B read data |
| b_pout | output | max(PB,1) | Port B read parity |

## Verification
The bench builds all 36 width pairings and runs each against a flat bit-level model of data and parity. Every address is first written through one port and read through the other, and then the roles swap. A wrong packing order, slice offset or parity lane shows up as a word that matches the model at one width only. A mixed random phase issues disabled accesses with the write enable high, reads and writes on both ports in the same cycle, and disjoint same-row writes. These separate a hold failure or a lost merge from a plain storage error. A reset in mid-run followed by readback tells a cleared output register apart from a cleared array.

// File: rtl/adp_pkg.sv
// Shared constants and width helpers for the dual-port memory.
// Assumes a port width is one of 1, 2, 4, 9, 18 or 36.
package adp_pkg;
    localparam int ROWS   = 512;               // stored rows
    localparam int ROW_AW = $clog2(ROWS);      // row index bits
    localparam int ROW_DW = 32;                // data bits per row
    localparam int ROW_PW = ROW_DW / 8;        // parity bits per row

    // data bits of a port of total width w
    function automatic int dbits(input int w);
        return w - (w / 9);
    endfunction

    // parity bits of a port of total width w
    function automatic int pbits(input int w);
        return w / 9;
    endfunction

    // address bits of a port of total width w
    function automatic int awidth(input int w);
        return ROW_AW + $clog2(ROW_DW) - $clog2(dbits(w));
    endfunction
endpackage

// File: rtl/adp_store.sv
// Row storage: ROWS rows of ROW_DW data bits plus ROW_PW parity bits.
// Each port supplies a row index and bit masks. When both ports write the
// same row, the two masked updates merge. Reads are combinational; the
// port modules register them. Assumes overlapping writes never occur.
module adp_store
    import adp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa,
    input  logic [ROW_AW-1:0] row_a,
    input  logic [ROW_DW-1:0] dm_a,
    input  logic [ROW_DW-1:0] dv_a,
    input  logic [ROW_PW-1:0] pm_a,
    input  logic [ROW_PW-1:0] pv_a,
    input  logic              wb,
    input  logic [ROW_AW-1:0] row_b,
    input  logic [ROW_DW-1:0] dm_b,
    input  logic [ROW_DW-1:0] dv_b,
    input  logic [ROW_PW-1:0] pm_b,
    input  logic [ROW_PW-1:0] pv_b,
    output logic [ROW_DW-1:0] rd_a,
    output logic [ROW_PW-1:0] rp_a,
    output logic [ROW_DW-1:0] rd_b,
    output logic [ROW_PW-1:0] rp_b
);
    logic [ROW_DW-1:0] dmem [ROWS];
    logic [ROW_PW-1:0] pmem [ROWS];
    logic [ROW_DW-1:0] nd_a, base_d, nd_b;
    logic [ROW_PW-1:0] np_a, base_p, np_b;
    logic              same_row;

    // Combinational read of both addressed rows
    assign rd_a = dmem[row_a];
    assign rp_a = pmem[row_a];
    assign rd_b = dmem[row_b];
    assign rp_b = pmem[row_b];

    // Build the new row values; B starts from A's result when both hit one row
    always_comb begin
        same_row = wa && (row_a == row_b);
        nd_a   = (dmem[row_a] & ~dm_a) | (dv_a & dm_a);
        np_a   = (pmem[row_a] & ~pm_a) | (pv_a & pm_a);
        base_d = same_row ? nd_a : dmem[row_b];
        base_p = same_row ? np_a : pmem[row_b];
        nd_b   = (base_d & ~dm_b) | (dv_b & dm_b);
        np_b   = (base_p & ~pm_b) | (pv_b & pm_b);
    end

    // Commit row writes; a same-row B write already carries A's bits
    always_ff @(posedge clk) begin
        if (wa) begin
            dmem[row_a] <= nd_a;
            pmem[row_a] <= np_a;
        end
        if (wb) begin
            dmem[row_b] <= nd_b;
            pmem[row_b] <= np_b;
        end
    end

    // R10
    no_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wa && wb && (row_a == row_b) && (((dm_a & dm_b) != '0) || ((pm_a & pm_b) != '0))));
endmodule

// File: rtl/adp_port.sv
// One access port of width W. Maps the word address to a row and a slot,
// builds the row write masks, and registers the read slice (write-first).
// Assumes W is a legal width; for W of 1, 2 or 4 the parity pins are dummies.
module adp_port
    import adp_pkg::*;
#(
    parameter int W = 36
) (
    clk, rst_n, en, we, addr, din, pin, dout, pout,
    wr, row, dmask, dval, pmask, pval, rd_d, rd_p
);
    localparam int DW    = dbits(W);
    localparam int PW    = pbits(W);
    localparam int PWP   = (PW == 0) ? 1 : PW;
    localparam int AW    = awidth(W);
    localparam int SLOTW = AW - ROW_AW;
    localparam logic [ROW_DW-1:0] DLANE = (DW == ROW_DW) ? '1 : ROW_DW'((64'd1 << DW) - 64'd1);
    localparam logic [ROW_PW-1:0] PLANE = ROW_PW'((8'd1 << PW) - 8'd1);

    input  logic              clk;
    input  logic              rst_n;
    input  logic              en;
    input  logic              we;
    input  logic [AW-1:0]     addr;
    input  logic [DW-1:0]     din;
    input  logic [PWP-1:0]    pin;
    output logic [DW-1:0]     dout;
    output logic [PWP-1:0]    pout;
    output logic              wr;
    output logic [ROW_AW-1:0] row;
    output logic [ROW_DW-1:0] dmask;
    output logic [ROW_DW-1:0] dval;
    output logic [ROW_PW-1:0] pmask;
    output logic [ROW_PW-1:0] pval;
    input  logic [ROW_DW-1:0] rd_d;
    input  logic [ROW_PW-1:0] rd_p;

    logic [4:0] slot;
    logic [4:0] doff;
    logic [1:0] poff;

    // Low address bits pick the slot within a row; full rows have one slot
    if (SLOTW > 0) begin : g_slot
        assign slot = 5'(addr[SLOTW-1:0]);
    end else begin : g_noslot
        assign slot = '0;
    end

    // Row index and bit offsets of this word
    always_comb begin
        row  = addr[AW-1 -: ROW_AW];
        doff = 5'(32'(slot) * DW);
        poff = 2'(32'(slot) * PW);
    end

    // Write request toward the storage, masked to this word's lanes
    always_comb begin
        wr    = en && we;
        dmask = wr ? (DLANE << doff) : '0;
        dval  = (ROW_DW'(din) << doff) & dmask;
        pmask = (wr && PW > 0) ? (PLANE << poff) : '0;
        pval  = (ROW_PW'(pin) << poff) & pmask;
    end

    // Output register: reset clears, write shows new data, read takes the slice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            pout <= '0;
        end else if (en) begin
            if (we) begin
                dout <= din;
                pout <= (PW > 0) ? pin : '0;
            end else begin
                dout <= DW'(rd_d >> doff);
                pout <= (PW > 0) ? PWP'(rd_p >> poff) : '0;
            end
        end
    end

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && pout == '0));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en) |=> ($stable(dout) && $stable(pout)));
    // R3
    wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (dout == $past(din)));
    // R8
    no_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PW == 0 && rst_n) |=> (pout == '0));
endmodule

// File: rtl/adp_ram.sv
// Two-port memory with independent port widths and byte parity.
// Port A and B each map onto the shared row store; width conversion follows
// from the common row layout. Assumes legal widths and no overlapping
// same-cycle writes.
module adp_ram
    import adp_pkg::*;
#(
    parameter int WIDTH_A = 36,
    parameter int WIDTH_B = 9
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         a_en,
    input  logic                                         a_we,
    input  logic [awidth(WIDTH_A)-1:0]                   a_addr,
    input  logic [dbits(WIDTH_A)-1:0]                    a_din,
    input  logic [((pbits(WIDTH_A) == 0) ? 1 : pbits(WIDTH_A))-1:0] a_pin,
    output logic [dbits(WIDTH_A)-1:0]                    a_dout,
    output logic [((pbits(WIDTH_A) == 0) ? 1 : pbits(WIDTH_A))-1:0] a_pout,
    input  logic                                         b_en,
    input  logic                                         b_we,
    input  logic [awidth(WIDTH_B)-1:0]                   b_addr,
    input  logic [dbits(WIDTH_B)-1:0]                    b_din,
    input  logic [((pbits(WIDTH_B) == 0) ? 1 : pbits(WIDTH_B))-1:0] b_pin,
    output logic [dbits(WIDTH_B)-1:0]                    b_dout,
    output logic [((pbits(WIDTH_B) == 0) ? 1 : pbits(WIDTH_B))-1:0] b_pout
);
    logic              wa, wb;
    logic [ROW_AW-1:0] row_a, row_b;
    logic [ROW_DW-1:0] dm_a, dv_a, dm_b, dv_b, rd_a, rd_b;
    logic [ROW_PW-1:0] pm_a, pv_a, pm_b, pv_b, rp_a, rp_b;

    adp_port #(.W(WIDTH_A)) port_a_i (
        .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we), .addr(a_addr),
        .din(a_din), .pin(a_pin), .dout(a_dout), .pout(a_pout),
        .wr(wa), .row(row_a), .dmask(dm_a), .dval(dv_a), .pmask(pm_a), .pval(pv_a),
        .rd_d(rd_a), .rd_p(rp_a)
    );

    adp_port #(.W(WIDTH_B)) port_b_i (
        .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we), .addr(b_addr),
        .din(b_din), .pin(b_pin), .dout(b_dout), .pout(b_pout),
        .wr(wb), .row(row_b), .dmask(dm_b), .dval(dv_b), .pmask(pm_b), .pval(pv_b),
        .rd_d(rd_b), .rd_p(rp_b)
    );

    adp_store store_i (
        .clk(clk), .rst_n(rst_n),
        .wa(wa), .row_a(row_a), .dm_a(dm_a), .dv_a(dv_a), .pm_a(pm_a), .pv_a(pv_a),
        .wb(wb), .row_b(row_b), .dm_b(dm_b), .dv_b(dv_b), .pm_b(pm_b), .pv_b(pv_b),
        .rd_a(rd_a), .rp_a(rp_a), .rd_b(rd_b), .rp_b(rp_b)
    );
endmodule

// File: tb/adp_ram_tb_cell.sv
// One width pairing: driver task pushes expected outputs into a queue,
// monitor pops and compares one cycle later against a flat bit model.
module adp_ram_tb_cell #(
    parameter int WA = 36,
    parameter int WB = 9
) (
    input  logic clk,
    output int   vec,
    output int   bad,
    output logic done
);
    import adp_pkg::*;
    localparam int DA  = dbits(WA);
    localparam int PA  = pbits(WA);
    localparam int PXA = (PA == 0) ? 1 : PA;
    localparam int AWA = awidth(WA);
    localparam int NA  = 1 << AWA;
    localparam int DB  = dbits(WB);
    localparam int PB  = pbits(WB);
    localparam int PXB = (PB == 0) ? 1 : PB;
    localparam int AWB = awidth(WB);
    localparam int NB  = 1 << AWB;

    logic           rst_n, a_en, a_we, b_en, b_we;
    logic [AWA-1:0] a_addr;
    logic [AWB-1:0] b_addr;
    logic [DA-1:0]  a_din, a_dout;
    logic [DB-1:0]  b_din, b_dout;
    logic [PXA-1:0] a_pin, a_pout;
    logic [PXB-1:0] b_pin, b_pout;

    adp_ram #(.WIDTH_A(WA), .WIDTH_B(WB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(a_dout), .a_pout(a_pout),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(b_dout), .b_pout(b_pout)
    );

    typedef struct {
        logic [31:0] ad;
        logic [3:0]  ap;
        logic [31:0] bd;
        logic [3:0]  bp;
        string       ta;
        string       tb;
    } item_t;

    item_t        q[$];
    item_t        it;
    logic [16383:0] rd;   // flat data model (R5, R6)
    logic [2047:0]  rp;   // flat parity model, index i pairs with data byte i (R7)
    logic [31:0]  lad, lbd;
    logic [3:0]   lap, lbp;

    // One cycle of stimulus; computes and queues the expected outputs
    task automatic step(input bit rs, input bit ea, input bit wa, input int aa,
                        input logic [31:0] da, input logic [3:0] pa,
                        input bit eb, input bit wb, input int ab,
                        input logic [31:0] db, input logic [3:0] pb,
                        input string ta, input string tb);
        item_t e;
        @(negedge clk);
        rst_n = !rs;
        a_en = ea; a_we = wa; a_addr = AWA'(aa); a_din = DA'(da); a_pin = PXA'(pa);
        b_en = eb; b_we = wb; b_addr = AWB'(ab); b_din = DB'(db); b_pin = PXB'(pb);
        if (rs) begin
            lad = '0; lap = '0; lbd = '0; lbp = '0;
        end else begin
            if (ea) begin
                if (wa) begin
                    lad = 32'(DA'(da));
                    lap = (PA > 0) ? 4'(PXA'(pa)) : 4'd0;
                end else begin
                    lad = 32'(rd[aa*DA +: DA]);
                    lap = (PA > 0) ? 4'(rp[aa*PXA +: PXA]) : 4'd0;
                end
            end
            if (eb) begin
                if (wb) begin
                    lbd = 32'(DB'(db));
                    lbp = (PB > 0) ? 4'(PXB'(pb)) : 4'd0;
                end else begin
                    lbd = 32'(rd[ab*DB +: DB]);
                    lbp = (PB > 0) ? 4'(rp[ab*PXB +: PXB]) : 4'd0;
                end
            end
            if (ea && wa) begin
                rd[aa*DA +: DA] = DA'(da);
                if (PA > 0) rp[aa*PXA +: PXA] = PXA'(pa);   // R8: no parity update otherwise
            end
            if (eb && wb) begin
                rd[ab*DB +: DB] = DB'(db);
                if (PB > 0) rp[ab*PXB +: PXB] = PXB'(pb);
            end
        end
        e.ad = lad; e.ap = lap; e.bd = lbd; e.bp = lbp; e.ta = ta; e.tb = tb;
        q.push_back(e);
    endtask

    // Monitor: compare one queued item per cycle, after the edge settles
    initial begin
        vec = 0;
        bad = 0;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                vec += 2;
                if (32'(a_dout) !== it.ad || 4'(a_pout) !== it.ap) begin
                    bad++;
                    $display("FAIL %s %s port A (x%0d/x%0d): dout=%h pout=%h expected %h %h",
                             it.ta, (PA > 0) ? "R7" : "R8", WA, WB, a_dout, a_pout, it.ad, it.ap);
                end
                if (32'(b_dout) !== it.bd || 4'(b_pout) !== it.bp) begin
                    bad++;
                    $display("FAIL %s %s port B (x%0d/x%0d): dout=%h pout=%h expected %h %h",
                             it.tb, (PB > 0) ? "R7" : "R8", WA, WB, b_dout, b_pout, it.bd, it.bp);
                end
            end
        end
    end

    // Driver: reset, full fill, cross-width passes, random mix, reset retention
    initial begin
        string tag_ab, tag_ba;
        done = 0;
        rd = '0; rp = '0;
        rst_n = 0; a_en = 0; a_we = 0; b_en = 0; b_we = 0;
        a_addr = '0; b_addr = '0; a_din = '0; b_din = '0; a_pin = '0; b_pin = '0;
        // R9: reset state
        repeat (3) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9", "R9");
        // R1: every address of the wider port, so the model is fully known
        if (WA >= WB) begin
            for (int a = 0; a < NA; a++)
                step(0, 1, 1, a, $urandom, 4'($urandom), 0, 0, 0, 0, 0, "R1", "R1");
        end else begin
            for (int b = 0; b < NB; b++)
                step(0, 0, 0, 0, 0, 0, 1, 1, b, $urandom, 4'($urandom), "R1", "R1");
        end
        // B writes, A reads: R5 when A is wider, R6 when narrower, R2 when equal
        tag_ab = (WA > WB) ? "R5" : (WA < WB) ? "R6" : "R2";
        tag_ba = (WB > WA) ? "R5" : (WB < WA) ? "R6" : "R2";
        for (int b = 0; b < NB; b++)
            step(0, 0, 0, 0, 0, 0, 1, 1, b, $urandom, 4'($urandom), "R4", "R3");
        for (int a = 0; a < NA; a++)
            step(0, 1, 0, a, $urandom, 4'($urandom), 0, 0, 0, 0, 0, tag_ab, "R4");
        // A writes, B reads
        for (int a = 0; a < NA; a++)
            step(0, 1, 1, a, $urandom, 4'($urandom), 0, 0, 0, 0, 0, "R3", "R4");
        for (int b = 0; b < NB; b++)
            step(0, 0, 0, 0, 0, 0, 1, 0, b, $urandom, 4'($urandom), "R4", tag_ba);
        // R4, R10: random mix, overlapping same-cycle accesses with a write avoided
        for (int k = 0; k < 2500; k++) begin
            bit ea, wa, eb, wb;
            int aa, ab, a0, b0;
            ea = ($urandom % 4) != 0; wa = $urandom % 2;
            eb = ($urandom % 4) != 0; wb = $urandom % 2;
            aa = (k % 5 == 0) ? 0 : int'($urandom % NA);
            ab = (k % 5 == 0) ? ((DB < 32) ? 1 : 0) : int'($urandom % NB);
            a0 = aa * DA; b0 = ab * DB;
            if (ea && eb && (wa || wb) && (a0 < b0 + DB) && (b0 < a0 + DA)) eb = 0;
            step(0, ea, wa, aa, $urandom, 4'($urandom), eb, wb, ab, $urandom, 4'($urandom),
                 "R4", "R10");
        end
        // R9: mid-run reset clears outputs, contents stay
        repeat (2) step(1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9", "R9");
        for (int k = 0; k < 16; k++)
            step(0, 1, 0, int'($urandom % NA), 0, 0, 1, 0, int'($urandom % NB), 0, 0, "R9", "R9");
        repeat (3) @(negedge clk);
        done = 1;
    end
endmodule

// File: tb/adp_ram_tb_top.sv
// Runs every pairing of the six port widths and prints one summary line.
module adp_ram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 6;
    localparam int NC = NW * NW;
    localparam int WL [NW] = '{1, 2, 4, 9, 18, 36};

    logic clk = 1'b0;
    int   vecs [NC];
    int   bads [NC];
    logic dn   [NC];

    // Free-running bench clock
    always #(CLK_PERIOD / 2) clk = ~clk;

    for (genvar i = 0; i < NW; i++) begin : g_a
        for (genvar j = 0; j < NW; j++) begin : g_b
            adp_ram_tb_cell #(.WA(WL[i]), .WB(WL[j])) cell_i (
                .clk(clk), .vec(vecs[i*NW+j]), .bad(bads[i*NW+j]), .done(dn[i*NW+j])
            );
        end
    end

    // Wait for all cells or the watchdog, then report
    initial begin
        int  cyc;
        int  tv;
        int  tf;
        bit  all;
        cyc = 0;
        all = 0;
        while (!all && cyc < 190000) begin
            @(posedge clk);
            cyc++;
            all = 1;
            for (int k = 0; k < NC; k++) if (dn[k] !== 1'b1) all = 0;
        end
        #2;
        tv = 0;
        tf = 0;
        for (int k = 0; k < NC; k++) begin
            tv += vecs[k];
            tf += bads[k];
        end
        if (!all) begin
            tf++;
            $display("FAIL watchdog (R2): cells done=0 expected 1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", tv, tf);
        $finish;
    end
endmodule